// File: doc/BRIEF.md
# Coin-Steered Filtered L1 Lookup Controller

This block controls tag lookup and line placement for a direct-mapped L1 that sits beside a small fully associative side buffer (the "filter"). For each CPU reference it checks the L1, then searches every filter slot at once, and asks the next level for the line only when both miss. The controller tracks tags and valid bits only. Data storage, coherence and write-back buffering are handled elsewhere, and writes are taken as write-through, so they behave like reads here.

Placement is steered by a biased coin, and no per-line history is kept. When a fill returns, a winning flip puts the line into the L1 and a losing flip puts it into the filter. A reference that hits in the filter also flips the coin, and a win moves that line up into the L1. The coin is flipped only at these decisions. It can be built two ways. One is a 16-bit maximal LFSR compared against a threshold scaled from SEL_NUM/SEL_DEN. The other is an accumulator that wins exactly once every time SEL_NUM/SEL_DEN adds up to a whole unit, which gives periodic selection at that rate.

Top module: `filtered_l1_ctrl`

## Requirements
- R1: After reset the block accepts requests (`cpu_req_ready`=1), shows no response and no next-level request, and every slot of both structures is empty, so the first reference misses.
- R2: A reference that hits the L1 responds in the cycle after acceptance with `cpu_resp_src`=0, sends no next-level request and does not flip the coin.
- R3: A reference that misses the L1 and hits the filter responds in the cycle after acceptance with `cpu_resp_src`=1 and sends no next-level request.
- R4: A reference that misses both raises `nl_req_valid` in the cycle after acceptance, with `nl_req_line` equal to the address with its offset bits removed. It holds both, with `cpu_req_ready`=0, until `nl_fill_valid`, and responds in the cycle after the fill with `cpu_resp_src`=2.
- R5: The coin is flipped once for each filter hit and once for each fill. In periodic mode with SEL_NUM=1 and SEL_DEN=3, flips 3, 6, 9, … counted from reset win and all others lose.
- R6: A winning fill writes the line into its L1 set and overwrites the line already there. A losing fill places the line into the filter.
- R7: A winning filter hit moves the line into the L1 and frees its filter slot. A line is never present in both structures.
- R8: A losing fill takes the lowest-numbered empty filter slot. When all slots are full, it takes the slot named by a round-robin pointer that starts at 0 and advances by one after each such replacement.
- R9: In LFSR mode with SEL_NUM=0, no reference ever places a line into the L1.
- R10: `cpu_resp_to_l1` is 1 exactly when the referenced line is held in the L1 after the reference: on an L1 hit, on a winning promotion and on a winning fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU reference present |
| cpu_req_addr | input | ADDR_W | Reference byte address |
| cpu_req_ready | output | 1 | Controller can accept a reference |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_src | output | 2 | Where the line was found: 0 L1, 1 filter, 2 next level |
| cpu_resp_to_l1 | output | 1 | Line is held in the L1 after this reference |
| nl_req_valid | output | 1 | Next-level line request pending |
| nl_req_line | output | ADDR_W-OFF_W | Line address requested |
| nl_fill_valid | input | 1 | Next level returns the requested line |

## Verification
The bench runs a reference model of the L1 sets, the filter slots, the round-robin pointer and the periodic accumulator, on a 4-set L1 and a 4-slot filter, across a long sweep of addresses that conflict heavily. The corner cases it targets are these:

- A promotion that fails to free its filter slot would later report a filter hit for a line that is already in the L1.
- A victim choice that ignores empty slots, or moves the pointer while slots are still empty, would evict the wrong line, and a later reference would miss where the model expects a hit.
- A coin that advances on L1 hits would shift every later win by one.

A second instance, built with the LFSR and a zero probability, checks that the L1 never gains a line and that the filter cycles its slots in order once it is full.

// File: rtl/filtered_l1_ctrl.sv
module filtered_l1_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 6,
  parameter int L1_SETS    = 64,
  parameter int FLT_LINES  = 16,
  parameter int SEL_RANDOM = 1,
  parameter int SEL_NUM    = 5,
  parameter int SEL_DEN    = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  output logic                    cpu_req_ready,
  output logic                    cpu_resp_valid,
  output logic [1:0]              cpu_resp_src,
  output logic                    cpu_resp_to_l1,
  output logic                    nl_req_valid,
  output logic [ADDR_W-OFF_W-1:0] nl_req_line,
  input  logic                    nl_fill_valid
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(L1_SETS);
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int SLOT_W = $clog2(FLT_LINES);

  logic [L1_SETS-1:0]   l1_v;
  logic [TAG_W-1:0]     l1_tag [L1_SETS];
  logic [FLT_LINES-1:0] f_v;
  logic [LINE_W-1:0]    f_line [FLT_LINES];
  logic [FLT_LINES-1:0] f_hit_vec;
  logic [SLOT_W-1:0]    rr, f_slot, free_slot, vic;
  logic                 miss_q, win;
  logic [LINE_W-1:0]    line_q;

  wire unused_off = ^cpu_req_addr[OFF_W-1:0];
  wire [LINE_W-1:0] cur_line = miss_q ? line_q : cpu_req_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0]  idx      = cur_line[IDX_W-1:0];
  wire [TAG_W-1:0]  tag      = cur_line[LINE_W-1:IDX_W];
  wire l1_hit   = l1_v[idx] && (l1_tag[idx] == tag);
  wire f_hit    = |f_hit_vec;
  wire any_free = ~&f_v;
  wire accept   = cpu_req_valid && !miss_q;
  wire fill     = miss_q && nl_fill_valid;
  wire decide   = (accept && !l1_hit && f_hit) || fill;

  assign cpu_req_ready = !miss_q;
  assign nl_req_valid  = miss_q;
  assign nl_req_line   = line_q;
  assign vic           = any_free ? free_slot : rr;

  for (genvar g = 0; g < FLT_LINES; g++) begin : g_cam
    assign f_hit_vec[g] = f_v[g] && (f_line[g] == cur_line);
  end

  always_comb begin
    f_slot = '0;
    for (int i = 0; i < FLT_LINES; i++)
      if (f_hit_vec[i]) f_slot = SLOT_W'(i);
  end

  always_comb begin
    free_slot = '0;
    for (int i = FLT_LINES - 1; i >= 0; i--)
      if (!f_v[i]) free_slot = SLOT_W'(i);
  end

  if (SEL_RANDOM != 0) begin : g_lfsr
    localparam int THR_I = (65536 * SEL_NUM) / SEL_DEN;
    localparam logic [16:0] THR = 17'(THR_I);
    logic [15:0] lfsr;
    assign win = {1'b0, lfsr} < THR;
    always_ff @(posedge clk)
      if (!rst_n)      lfsr <= 16'hACE1;
      else if (decide) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end else begin : g_period
    localparam int ACC_W = $clog2(2 * SEL_DEN + 1);
    logic [ACC_W-1:0] acc;
    wire  [ACC_W-1:0] sum = acc + ACC_W'(SEL_NUM);
    assign win = sum >= ACC_W'(SEL_DEN);
    always_ff @(posedge clk)
      if (!rst_n)      acc <= '0;
      else if (decide) acc <= win ? sum - ACC_W'(SEL_DEN) : sum;
  end

  wire l1_write = decide && win;

  always_ff @(posedge clk)
    if (l1_write) l1_tag[idx] <= tag;

  always_ff @(posedge clk)
    if (fill && !win) f_line[vic] <= cur_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_v           <= '0;
      f_v            <= '0;
      rr             <= '0;
      miss_q         <= 1'b0;
      line_q         <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_src   <= 2'd0;
      cpu_resp_to_l1 <= 1'b0;
    end else begin
      cpu_resp_valid <= 1'b0;
      if (l1_write) l1_v[idx] <= 1'b1;
      if (accept) begin
        if (l1_hit) begin
          cpu_resp_valid <= 1'b1;
          cpu_resp_src   <= 2'd0;
          cpu_resp_to_l1 <= 1'b1;
        end else if (f_hit) begin
          cpu_resp_valid <= 1'b1;
          cpu_resp_src   <= 2'd1;
          cpu_resp_to_l1 <= win;
          if (win) f_v[f_slot] <= 1'b0;
        end else begin
          miss_q <= 1'b1;
          line_q <= cur_line;
        end
      end else if (fill) begin
        miss_q         <= 1'b0;
        cpu_resp_valid <= 1'b1;
        cpu_resp_src   <= 2'd2;
        cpu_resp_to_l1 <= win;
        if (!win) begin
          f_v[vic] <= 1'b1;
          if (!any_free) rr <= (rr == SLOT_W'(FLT_LINES - 1)) ? '0 : rr + 1'b1;
        end
      end
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && !nl_fill_valid) |=> (nl_req_valid && $stable(nl_req_line) && !cpu_req_ready));
  a_r4_fill_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && nl_fill_valid) |=> (cpu_resp_valid && cpu_resp_src == 2'd2 && cpu_req_ready));
  a_r2_l1_resident: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_resp_valid && cpu_resp_src == 2'd0) |-> cpu_resp_to_l1);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_hit && f_hit));
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_hit_vec));
  a_r9_never_l1: assert property (@(posedge clk) disable iff (!rst_n)
    (SEL_NUM == 0 && cpu_resp_valid) |-> (!cpu_resp_to_l1 || cpu_resp_src == 2'd0));
  a_r1_src_code: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> (cpu_resp_src != 2'd3));
endmodule

// File: tb/filtered_l1_ctrl_tb.sv
`timescale 1ns/1ps
module filtered_l1_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic a_v = 0, a_fill = 0, a_ready, a_rv, a_to, a_nlv;
  logic [15:0] a_addr = '0;
  logic [1:0]  a_src;
  logic [11:0] a_nll;
  logic b_v = 0, b_fill = 0, b_ready, b_rv, b_to, b_nlv;
  logic [15:0] b_addr = '0;
  logic [1:0]  b_src;
  logic [11:0] b_nll;

  filtered_l1_ctrl #(.ADDR_W(16), .OFF_W(4), .L1_SETS(4), .FLT_LINES(4),
    .SEL_RANDOM(0), .SEL_NUM(1), .SEL_DEN(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(a_v), .cpu_req_addr(a_addr),
    .cpu_req_ready(a_ready), .cpu_resp_valid(a_rv), .cpu_resp_src(a_src),
    .cpu_resp_to_l1(a_to), .nl_req_valid(a_nlv), .nl_req_line(a_nll),
    .nl_fill_valid(a_fill));

  filtered_l1_ctrl #(.ADDR_W(16), .OFF_W(4), .L1_SETS(4), .FLT_LINES(4),
    .SEL_RANDOM(1), .SEL_NUM(0), .SEL_DEN(1)) u_dut_lfsr (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(b_v), .cpu_req_addr(b_addr),
    .cpu_req_ready(b_ready), .cpu_resp_valid(b_rv), .cpu_resp_src(b_src),
    .cpu_resp_to_l1(b_to), .nl_req_valid(b_nlv), .nl_req_line(b_nll),
    .nl_fill_valid(b_fill));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_l1v[4], m_l1t[4], m_fv[4], m_fl[4];
  int m_rr = 0, m_acc = 0;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic coin(output bit w);
    m_acc++;
    w = (m_acc >= 3);
    if (w) m_acc -= 3;
  endtask

  task automatic model(input int line, output int es, output int et);
    int idx, tg, s, fs;
    bit w;
    idx = line % 4; tg = line / 4; s = -1;
    for (int i = 0; i < 4; i++) if (m_fv[i] != 0 && m_fl[i] == line) s = i;
    if (m_l1v[idx] != 0 && m_l1t[idx] == tg) begin
      es = 0; et = 1;
    end else if (s >= 0) begin
      coin(w); es = 1; et = w;
      if (w) begin m_l1v[idx] = 1; m_l1t[idx] = tg; m_fv[s] = 0; end
    end else begin
      coin(w); es = 2; et = w;
      if (w) begin m_l1v[idx] = 1; m_l1t[idx] = tg; end
      else begin
        fs = -1;
        for (int i = 3; i >= 0; i--) if (m_fv[i] == 0) fs = i;
        if (fs < 0) begin fs = m_rr; m_rr = (m_rr + 1) % 4; end
        m_fv[fs] = 1; m_fl[fs] = line;
      end
    end
  endtask

  task automatic drive(input bit which, input int line, output int src, output int to, output int nl_ok);
    int n;
    @(negedge clk);
    if (which) begin b_v = 1; b_addr = {line[11:0], 4'h9}; end
    else       begin a_v = 1; a_addr = {line[11:0], 4'h9}; end
    @(negedge clk);
    a_v = 0; b_v = 0;
    nl_ok = 1; n = 0;
    while (!(which ? b_rv : a_rv) && n < 20) begin
      if (which ? b_nlv : a_nlv) begin
        if ((which ? b_nll : a_nll) != line[11:0]) nl_ok = 0;
        @(negedge clk);
        if ((which ? b_ready : a_ready) || !(which ? b_nlv : a_nlv)) nl_ok = 0;
        if (which) b_fill = 1; else a_fill = 1;
        @(negedge clk);
        a_fill = 0; b_fill = 0;
      end else @(negedge clk);
      n++;
    end
    src = (which ? b_rv : a_rv) ? int'(which ? b_src : a_src) : 3;
    to  = int'(which ? b_to : a_to);
  endtask

  task automatic ref_main(input int line, input string tag);
    int es, et, s, t, ok;
    model(line, es, et);
    drive(0, line, s, t, ok);
    check({tag, " src"}, s, es);
    check({tag, " R10 to_l1"}, t, et);
    if (es == 2) check("R4 line/hold", ok, 1);
  endtask

  task automatic ref_lfsr(input int line, input int es);
    int s, t, ok;
    drive(1, line, s, t, ok);
    check("R9 src", s, es);
    check("R9 to_l1", t, 0);
    if (es == 2) check("R4 line/hold", ok, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_l1v[i] = 0; m_fv[i] = 0; m_l1t[i] = 0; m_fl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", int'(a_ready), 1);
    check("R1 resp", int'(a_rv), 0);
    check("R1 nl_req", int'(a_nlv), 0);
    check("R1 lfsr ready", int'(b_ready), 1);

    ref_main(0,  "R1 R4");
    ref_main(0,  "R3");
    ref_main(0,  "R7");
    ref_main(0,  "R2");
    ref_main(4,  "R8");
    ref_main(8,  "R8");
    ref_main(12, "R6");
    ref_main(0,  "R6");
    ref_main(1,  "R8");
    ref_main(2,  "R5");
    ref_main(3,  "R8");
    ref_main(4,  "R8");
    ref_main(8,  "R8");
    for (int i = 0; i < 400; i++) ref_main((i * i * 5 + i * 3 + i / 7) % 16, "R5 sweep");

    ref_lfsr(0, 2);  ref_lfsr(0, 1);  ref_lfsr(0, 1);
    ref_lfsr(16, 2); ref_lfsr(32, 2); ref_lfsr(48, 2);
    ref_lfsr(64, 2); ref_lfsr(0, 2);  ref_lfsr(16, 2);
    ref_lfsr(48, 1); ref_lfsr(64, 1); ref_lfsr(32, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule